// File: doc/BRIEF.md
# Security-Aware Ownership Controller for a Shared Accelerator

This block is an APB slave that puts a hardware mutex in front of a shared compute engine. Each bus transfer carries a security attribute on PPROT[1]: 0 is a secure request and 1 is a non-secure request. A master claims the engine by reading the lock register. It gives the engine back by writing the release register. The owner is recorded as a security state, secure or non-secure, and not as a master number. Any request made in the owning state counts as the owner.

While a secure owner holds the lock, every non-secure transfer is refused. A refused transfer ends with PSLVERR high and zero read data, and it changes nothing. A secure master can take the lock from a non-secure owner by writing the preemption register. Once that happens, the old owner is locked out until the lock is free again.

The owner selects an operation mode and launches the engine through the control register. It then polls the status register for busy, done and two error flags. A stub engine stands in for the real datapath. It raises done a fixed number of cycles after each accepted start.

Top module: `secure_mutex_apb`

Register offsets: 0x00 lock, 0x04 release, 0x08 preempt, 0x0C control (mode in bits [3:0], start in bit 8, start reads 0), 0x10 status. Status bit positions: [0] busy, [1] done, [2] start-while-busy error, [3] start-without-ownership error, [4] lock held, [5] owner is secure.

## Requirements
- R1: After reset the lock is free, status reads 0, control reads 0 and PSLVERR is low.
- R2: A read of offset 0x00 while the lock is free returns 1 and makes the requester's security state the owner (status bit 4 set, bit 5 = 1 for secure, 0 for non-secure).
- R3: A read of offset 0x00 while the lock is held returns 0 and leaves owner state unchanged.
- R4: A write to offset 0x04 from the owning state frees the lock; the same write from the other state has no effect.
- R5: While a secure owner holds the lock, a non-secure transfer to any offset completes with PSLVERR = 1 and read data 0, and changes no register or lock state.
- R6: A secure write to offset 0x08 makes the secure state the owner when the lock is free or held by the non-secure state; a non-secure write there has no effect.
- R7: After a secure preemption, a release write from the former non-secure owner is refused (PSLVERR = 1) and the lock stays secure-owned.
- R8: An owner write to 0x0C stores bits [3:0] as the mode, readable back; with bit 8 set and the engine idle, busy (status bit 0) reads 1 on the next transfer.
- R9: Done (status bit 1) is set and busy cleared exactly 16 clock edges after the edge that accepts the start; busy holds until then.
- R10: A start while busy sets status bit 2 and does not restart or extend the running operation.
- R11: A start from a requester that does not own the lock (including a free lock) sets status bit 3 and does not launch the engine; mode writes from a non-owner are ignored.
- R12: Done clears on an accepted start or on an owner write of 1 to bit 1; error bits clear on owner writes of 1 to bits 2 and 3; non-owner status writes are ignored.
- R13: PREADY is always 1, and unmapped offsets read 0 without PSLVERR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pprot | input | 3 | Protection attribute; bit 1 high = non-secure |
| prdata | output | DATA_W | Read data |
| pready | output | 1 | Transfer complete (tied high) |
| pslverr | output | 1 | Refused transfer |

## Verification
The bench first targets the lockout after a preemption. A design that kept the old owner's identity would accept its release and drop the secure owner's lock. It checks that a refused transfer has no side effects. A design that decoded before gating would claim the lock, or rewrite the mode, on a transfer it had just rejected. Start timing is sampled one edge before and exactly on the completion edge. An off-by-one counter, or a second start that reloads the counter, shows up as busy at the wrong edge. Non-owner starts and status writes are also exercised, because a design that checked only busy would launch the engine for a master that holds no lock.

// File: rtl/apb_mutex_pkg.sv
package apb_mutex_pkg;

    localparam int unsigned OFS_LOCK    = 32'h00;
    localparam int unsigned OFS_RELEASE = 32'h04;
    localparam int unsigned OFS_PREEMPT = 32'h08;
    localparam int unsigned OFS_CTRL    = 32'h0C;
    localparam int unsigned OFS_STATUS  = 32'h10;

    localparam int unsigned START_BIT    = 8;
    localparam int unsigned ST_BUSY      = 0;
    localparam int unsigned ST_DONE      = 1;
    localparam int unsigned ST_ERR_BUSY  = 2;
    localparam int unsigned ST_ERR_OWNER = 3;
    localparam int unsigned ST_HELD      = 4;
    localparam int unsigned ST_OWNER_SEC = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOCK,
        SEL_RELEASE,
        SEL_PREEMPT,
        SEL_CTRL,
        SEL_STATUS
    } reg_sel_e;

    typedef struct packed {
        logic held;
        logic owner_sec;
    } lock_state_t;

endpackage

// File: rtl/apb_reg_decode.sv
module apb_reg_decode
    import apb_mutex_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] paddr_i,
    output reg_sel_e          sel_o
);

    always_comb begin
        sel_o = SEL_NONE;
        if (paddr_i == ADDR_W'(OFS_LOCK))    sel_o = SEL_LOCK;
        if (paddr_i == ADDR_W'(OFS_RELEASE)) sel_o = SEL_RELEASE;
        if (paddr_i == ADDR_W'(OFS_PREEMPT)) sel_o = SEL_PREEMPT;
        if (paddr_i == ADDR_W'(OFS_CTRL))    sel_o = SEL_CTRL;
        if (paddr_i == ADDR_W'(OFS_STATUS))  sel_o = SEL_STATUS;
    end

endmodule

// File: rtl/mutex_lock_core.sv
module mutex_lock_core
    import apb_mutex_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq_i,
    input  logic rel_i,
    input  logic pre_i,
    input  logic sec_i,
    output logic held_o,
    output logic owner_sec_o,
    output logic is_owner_o
);

    lock_state_t lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (acq_i && !lock_q.held) begin
            lock_d.held      = 1'b1;
            lock_d.owner_sec = sec_i;
        end
        if (rel_i && lock_q.held && (lock_q.owner_sec == sec_i)) begin
            lock_d.held      = 1'b0;
            lock_d.owner_sec = 1'b0;
        end
        if (pre_i && sec_i && !(lock_q.held && lock_q.owner_sec)) begin
            lock_d.held      = 1'b1;
            lock_d.owner_sec = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign held_o      = lock_q.held;
    assign owner_sec_o = lock_q.owner_sec;
    assign is_owner_o  = lock_q.held && (lock_q.owner_sec == sec_i);

    // R2
    acquire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_i && !held_o) |=> (held_o && (owner_sec_o == $past(sec_i))));

    // R3
    acquire_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_i && held_o) |=> ($stable(held_o) && $stable(owner_sec_o)));

    // R4
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i && held_o && (owner_sec_o != sec_i)) |=> (held_o && $stable(owner_sec_o)));

    // R6
    preempt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && sec_i) |=> (held_o && owner_sec_o));

endmodule

// File: rtl/stub_engine.sv
module stub_engine #(
    parameter int unsigned LATENCY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic finish_o
);

    localparam int unsigned CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (start_i && !eng_q.busy) begin
            eng_d.busy = 1'b1;
            eng_d.cnt  = CNT_W'(LATENCY - 1);
        end else if (eng_q.busy) begin
            if (eng_q.cnt == '0) eng_d.busy = 1'b0;
            else                 eng_d.cnt  = eng_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy_o   = eng_q.busy;
    assign finish_o = eng_q.busy && (eng_q.cnt == '0);

    // R10
    start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R8
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R9
    no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finish_o) |=> busy_o);

    // R9
    finish_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_o |=> !busy_o);

endmodule

// File: rtl/secure_mutex_apb.sv
module secure_mutex_apb
    import apb_mutex_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned MODE_W  = 4,
    parameter int unsigned LATENCY = 16
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [2:0]        pprot,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);

    localparam int unsigned ST_W = ST_OWNER_SEC + 1;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              done;
        logic              err_busy;
        logic              err_owner;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     access, req_sec, blocked, granted;
    logic     held, owner_sec, is_owner;
    logic     acq, rel, pre, eng_start, eng_busy, eng_finish;
    logic [ST_W-1:0] status_w;
    logic     unused_bits;

    assign unused_bits = ^{pprot[2], pprot[0], pwdata};

    apb_reg_decode #(.ADDR_W(ADDR_W)) decode_i (
        .paddr_i (paddr),
        .sel_o   (sel)
    );

    assign access  = psel && penable;
    assign req_sec = !pprot[1];
    assign blocked = access && !req_sec && held && owner_sec;
    assign granted = access && !blocked;

    assign acq = granted && !pwrite && (sel == SEL_LOCK);
    assign rel = granted &&  pwrite && (sel == SEL_RELEASE);
    assign pre = granted &&  pwrite && (sel == SEL_PREEMPT);

    mutex_lock_core lock_i (
        .clk         (pclk),
        .rst_n       (presetn),
        .acq_i       (acq),
        .rel_i       (rel),
        .pre_i       (pre),
        .sec_i       (req_sec),
        .held_o      (held),
        .owner_sec_o (owner_sec),
        .is_owner_o  (is_owner)
    );

    stub_engine #(.LATENCY(LATENCY)) engine_i (
        .clk      (pclk),
        .rst_n    (presetn),
        .start_i  (eng_start),
        .busy_o   (eng_busy),
        .finish_o (eng_finish)
    );

    always_comb begin
        regs_d    = regs_q;
        eng_start = 1'b0;
        if (granted && pwrite && (sel == SEL_CTRL)) begin
            if (is_owner) regs_d.mode = pwdata[MODE_W-1:0];
            if (pwdata[START_BIT]) begin
                if (!is_owner)     regs_d.err_owner = 1'b1;
                else if (eng_busy) regs_d.err_busy  = 1'b1;
                else begin
                    eng_start   = 1'b1;
                    regs_d.done = 1'b0;
                end
            end
        end
        if (granted && pwrite && (sel == SEL_STATUS) && is_owner) begin
            if (pwdata[ST_DONE])      regs_d.done      = 1'b0;
            if (pwdata[ST_ERR_BUSY])  regs_d.err_busy  = 1'b0;
            if (pwdata[ST_ERR_OWNER]) regs_d.err_owner = 1'b0;
        end
        if (eng_finish) regs_d.done = 1'b1;
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) regs_q <= '0;
        else          regs_q <= regs_d;
    end

    assign status_w = {owner_sec, held, regs_q.err_owner, regs_q.err_busy,
                       regs_q.done, eng_busy};

    always_comb begin
        prdata = '0;
        if (granted && !pwrite) begin
            case (sel)
                SEL_LOCK:   prdata = DATA_W'(!held);
                SEL_CTRL:   prdata = DATA_W'(regs_q.mode);
                SEL_STATUS: prdata = DATA_W'(status_w);
                default:    prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = blocked;

    // R5
    refused_in_access_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |-> (psel && penable && prdata == '0));

    // R5
    refused_no_effect_chk: assert property (@(posedge pclk) disable iff (!presetn)
        pslverr |=> ($stable(held) && $stable(owner_sec) && $stable(regs_q.mode)
                     && $stable(regs_q.err_busy) && $stable(regs_q.err_owner)));

    // R7
    secure_hold_kept_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (access && !req_sec && held && owner_sec) |=> (held && owner_sec));

endmodule

// File: tb/secure_mutex_apb_tb.sv
module secure_mutex_apb_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic        ns;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
    } vec_t;

    // Lock ownership sequence; requirement noted beside each step.
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'h10, 32'h0,   32'h00, 1'b0},  // R1 status idle
        '{1'b0, 1'b1, 8'h00, 32'h0,   32'h01, 1'b0},  // R2 NS claims
        '{1'b0, 1'b1, 8'h10, 32'h0,   32'h10, 1'b0},  // R2 held, NS owner
        '{1'b0, 1'b0, 8'h00, 32'h0,   32'h00, 1'b0},  // R3 secure claim fails
        '{1'b0, 1'b1, 8'h00, 32'h0,   32'h00, 1'b0},  // R3 owner re-claim returns 0
        '{1'b1, 1'b0, 8'h04, 32'h0,   32'h00, 1'b0},  // R4 foreign release
        '{1'b0, 1'b0, 8'h10, 32'h0,   32'h10, 1'b0},  // R4 still NS-owned
        '{1'b1, 1'b1, 8'h08, 32'h0,   32'h00, 1'b0},  // R6 NS preempt ignored
        '{1'b0, 1'b1, 8'h10, 32'h0,   32'h10, 1'b0},  // R6 unchanged
        '{1'b1, 1'b0, 8'h08, 32'h0,   32'h00, 1'b0},  // R6 secure preempt
        '{1'b0, 1'b0, 8'h10, 32'h0,   32'h30, 1'b0},  // R6 secure owner
        '{1'b1, 1'b1, 8'h04, 32'h0,   32'h00, 1'b1},  // R7 old owner release refused
        '{1'b0, 1'b1, 8'h10, 32'h0,   32'h00, 1'b1},  // R5 NS read refused
        '{1'b0, 1'b1, 8'h00, 32'h0,   32'h00, 1'b1},  // R5 NS claim refused
        '{1'b0, 1'b0, 8'h10, 32'h0,   32'h30, 1'b0},  // R7 still secure-owned
        '{1'b1, 1'b1, 8'h0C, 32'h105, 32'h00, 1'b1},  // R5 NS control write refused
        '{1'b0, 1'b0, 8'h0C, 32'h0,   32'h00, 1'b0},  // R5 mode untouched
        '{1'b0, 1'b0, 8'h3C, 32'h0,   32'h00, 1'b0},  // R13 unmapped reads 0
        '{1'b1, 1'b0, 8'h04, 32'h0,   32'h00, 1'b0},  // R4 owner release
        '{1'b0, 1'b0, 8'h10, 32'h0,   32'h00, 1'b0},  // R4 free
        '{1'b0, 1'b0, 8'h00, 32'h0,   32'h01, 1'b0},  // R2 secure claims
        '{1'b0, 1'b0, 8'h10, 32'h0,   32'h30, 1'b0},  // R2 secure owner
        '{1'b1, 1'b0, 8'h04, 32'h0,   32'h00, 1'b0},  // R4 release
        '{1'b0, 1'b1, 8'h10, 32'h0,   32'h00, 1'b0}   // R4 NS access allowed again
    };

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [2:0]  pprot = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        ready_seen_low = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [31:0] rd;
    logic        er;

    always #(CLK_PERIOD/2) clk = ~clk;

    secure_mutex_apb dut_i (
        .pclk    (clk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pprot   (pprot),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the access edge.
    task automatic xfer(input logic wr, input logic ns, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] r, output logic e);
        psel = 1'b1; penable = 1'b0; pwrite = wr;
        pprot = {1'b0, ns, 1'b0}; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        r = prdata; e = pslverr;
        if (pready !== 1'b1) ready_seen_low = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        check("R1 pslverr in reset", {31'b0, pslverr}, 32'h0);
        presetn = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].wr, VECS[i].ns, VECS[i].addr, VECS[i].wdata, rd, er);
            check($sformatf("vector %0d rdata", i), rd, VECS[i].exp_rd);
            check($sformatf("vector %0d pslverr", i), {31'b0, er}, {31'b0, VECS[i].exp_err});
        end

        // Operation A: mode, start, start-while-busy, timing edge 15
        xfer(1'b0, 1'b0, 8'h00, 32'h0, rd, er);
        check("R2 secure claim", rd, 32'h1);
        xfer(1'b1, 1'b0, 8'h0C, 32'h005, rd, er);
        xfer(1'b0, 1'b0, 8'h0C, 32'h0, rd, er);
        check("R8 mode readback", rd, 32'h5);
        xfer(1'b1, 1'b0, 8'h0C, 32'h105, rd, er);          // start accepted at E0
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);            // samples after E1
        check("R8 busy after start", rd, 32'h31);
        xfer(1'b1, 1'b0, 8'h0C, 32'h105, rd, er);          // start while busy, E4
        idle(10);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);            // samples after E15
        check("R9 R10 busy at edge 15, busy error", rd, 32'h35);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);            // samples after E17
        check("R10 finished, not restarted", rd, 32'h36);
        xfer(1'b1, 1'b0, 8'h10, 32'h04, rd, er);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);
        check("R12 busy error cleared", rd, 32'h32);

        // Operation B: done cleared by start, done exactly at edge 16
        xfer(1'b1, 1'b0, 8'h0C, 32'h105, rd, er);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);
        check("R12 done cleared by start", rd, 32'h31);
        idle(13);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);            // samples after E16
        check("R9 done at edge 16", rd, 32'h32);
        xfer(1'b1, 1'b0, 8'h10, 32'h02, rd, er);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);
        check("R12 done write-one-clear", rd, 32'h30);

        // Non-owner starts and status writes
        xfer(1'b1, 1'b0, 8'h04, 32'h0, rd, er);
        xfer(1'b1, 1'b0, 8'h0C, 32'h100, rd, er);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);
        check("R11 start on free lock", rd, 32'h08);
        xfer(1'b0, 1'b0, 8'h0C, 32'h0, rd, er);
        check("R11 mode kept on non-owner write", rd, 32'h5);
        xfer(1'b1, 1'b0, 8'h10, 32'h08, rd, er);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);
        check("R12 non-owner clear ignored", rd, 32'h08);
        xfer(1'b0, 1'b1, 8'h00, 32'h0, rd, er);
        check("R2 NS claim", rd, 32'h1);
        xfer(1'b1, 1'b1, 8'h10, 32'h08, rd, er);
        xfer(1'b0, 1'b1, 8'h10, 32'h0, rd, er);
        check("R12 owner clears owner error", rd, 32'h10);
        xfer(1'b1, 1'b0, 8'h0C, 32'h100, rd, er);
        xfer(1'b0, 1'b1, 8'h10, 32'h0, rd, er);
        check("R11 secure non-owner start", rd, 32'h18);

        check("R13 pready stayed high", {31'b0, ready_seen_low}, 32'h0);

        // Reset with state present
        presetn = 1'b0;
        idle(2);
        presetn = 1'b1;
        @(negedge clk);
        xfer(1'b0, 1'b0, 8'h10, 32'h0, rd, er);
        check("R1 status after reset", rd, 32'h0);
        xfer(1'b0, 1'b0, 8'h0C, 32'h0, rd, er);
        check("R1 control after reset", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule